// File: doc/BRIEF.md
# Packet Check-Sequence Appender with Fault Injection

This stage sits in a byte-wide packet path. Each packet arrives on a valid/ready stream with first-byte and last-byte markers. The stage forwards the data bytes unchanged and with no added latency. It runs a cyclic redundancy check over every byte of the packet. After the last data byte it sends the inverted check value as two or four extra bytes, least significant byte first, and moves the last-byte marker onto the final check byte. Configuration selects the 16-bit or 32-bit check, turns appending on or off, and can switch the whole stage to a plain pass-through.

For test purposes the stage can corrupt the check value of chosen packets. Each corrupted packet has exactly one inverted check bit, and that bit position steps forward on every corrupted packet. There are two trigger modes. In manual mode a trigger pulse arms a one-shot request that lands on the next packet. In programmed mode a trigger pulse starts a burst with a set number of corrupted packets and a set spacing between them.

Top module: `fcs_inserter`

## Requirements
- R1: After reset, with no input offered, out_valid is low and in_ready follows out_ready.
- R2: In 32-bit mode the check uses the reflected polynomial 0xEDB88320, preset to all ones at each packet's first byte, processing each byte least significant bit first. The ones' complement of the result is sent least significant byte first. The nine bytes "123456789" yield the trailer 26 39 F4 CB.
- R3: In 16-bit mode the check uses the reflected polynomial 0x8408, preset to 0xFFFF, with the same bit order, inversion and byte order. The nine bytes "123456789" yield the trailer 6E 90.
- R4: Data bytes leave in order and unchanged. out_sop marks the first data byte. With appending, out_eop marks only the last check byte, and in_ready stays low while check bytes are being sent.
- R5: A check byte offered while out_ready is low stays offered and unchanged until it is accepted.
- R6: With cfg_append_en low, a packet passes with no check bytes, and out_eop marks its last data byte.
- R7: With cfg_proc_en low, the stage is a pure pass-through whatever the other settings are. Such a packet takes no injection request and does not move the injection state.
- R8: A corrupted packet differs from the correct trailer in exactly one bit. Check bit k is bit k mod 8 of trailer byte k div 8.
- R9: The corrupted bit index is 0 after reset and advances by one on each corrupted packet. It wraps to 0 once it has been used at or above width−1 (15 or 31). In 16-bit mode the index used is the stored index modulo 16.
- R10: When cfg_inj_manual is low, an inj_trig pulse loads count N and period P. The first appended packet that starts after the pulse is corrupted, then every P-th appended packet after it, until N packets are corrupted. A period of 0 acts as 1.
- R11: When cfg_inj_manual is high, an inj_trig pulse arms one request. The request corrupts the next appended packet that starts after the pulse. Several pulses before that packet merge into one request.
- R12: Packets without a trailer neither take an injection request nor advance the programmed burst.
- R13: Mode, append and processing settings are taken when a packet's first byte is accepted. Changes during the packet do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_proc_en | input | 1 | Processing enable; low gives pure pass-through |
| cfg_append_en | input | 1 | Append the check trailer |
| cfg_fcs32 | input | 1 | 1 = 32-bit check, 0 = 16-bit check |
| cfg_inj_manual | input | 1 | Injection trigger mode: 1 manual, 0 programmed burst |
| cfg_inj_count | input | CNT_W | Number of corrupted packets in a programmed burst |
| cfg_inj_period | input | CNT_W | Packet spacing between corrupted packets in a burst |
| inj_trig | input | 1 | Injection trigger pulse |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_eop | input | 1 | Input byte is the last of a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is the first of a packet |
| out_eop | output | 1 | Output byte is the last of a packet |

## Verification
The hardest state to reach is a stored error index that has wrapped, or that sits above 15 while a 16-bit packet starts. Getting there takes a long run of corrupted packets in one burst. The bench resets, programs a 16-bit burst longer than the index range with period 1, and compares every trailer against its own model of the index. It also mixes mode changes part-way through a packet and bypassed packets with an injection request still pending, so that the one-shot latch has to survive packets that must not consume it.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(CRC_W);
  localparam logic [CRC_W-1:0] POLY_WIDE   = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] POLY_NARROW = 32'h0000_8408;
  localparam logic [CRC_W-1:0] SEED_WIDE   = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] SEED_NARROW = 32'h0000_FFFF;

  // One byte through the reflected LFSR, lowest data bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic wide);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (wide ? POLY_WIDE : POLY_NARROW);
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_crc_unit.sv
module fcs_crc_unit
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              first,
  input  logic              wide,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] crc_d;

  always_comb begin
    base  = first ? (wide ? SEED_WIDE : SEED_NARROW) : crc_q;
    crc_d = crc_q;
    if (byte_en) crc_d = crc_step(base, data, wide);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/fcs_err_sched.sv
module fcs_err_sched
  import fcs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             manual,
  input  logic [CNT_W-1:0] cnt_cfg,
  input  logic [CNT_W-1:0] per_cfg,
  input  logic             pkt_start,
  input  logic             wide,
  output logic             pkt_err,
  output logic [IDX_W-1:0] pkt_idx
);
  localparam logic [IDX_W-1:0] TOP_WIDE   = IDX_W'(CRC_W - 1);
  localparam logic [IDX_W-1:0] TOP_NARROW = IDX_W'(CRC_W / 2 - 1);

  logic [CNT_W-1:0] rem_q, rem_d, gap_q, gap_d;
  logic [IDX_W-1:0] idx_q, idx_d, cur_q, cur_d;
  logic             pend_q, pend_d, err_q, err_d;
  logic             hit;

  always_comb begin
    hit    = manual ? pend_q : ((rem_q != '0) && (gap_q == '0));
    rem_d  = rem_q;
    gap_d  = gap_q;
    idx_d  = idx_q;
    cur_d  = cur_q;
    pend_d = pend_q;
    err_d  = err_q;
    if (pkt_start) begin
      err_d = hit;
      if (hit) begin
        cur_d = wide ? idx_q : (idx_q & TOP_NARROW);
        idx_d = (idx_q >= (wide ? TOP_WIDE : TOP_NARROW)) ? '0 : idx_q + 1'b1;
      end
      if (manual) begin
        if (hit) pend_d = 1'b0;
      end else if (rem_q != '0) begin
        if (gap_q == '0) begin
          rem_d = rem_q - 1'b1;
          gap_d = (per_cfg == '0) ? '0 : per_cfg - 1'b1;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
    end
    if (trig) begin
      if (manual) pend_d = 1'b1;
      else begin
        rem_d = cnt_cfg;
        gap_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      gap_q  <= '0;
      idx_q  <= '0;
      cur_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      gap_q  <= gap_d;
      idx_q  <= idx_d;
      cur_q  <= cur_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign pkt_err = err_q;
  assign pkt_idx = cur_q;
endmodule

// File: rtl/fcs_inserter.sv
module fcs_inserter
  import fcs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_proc_en,
  input  logic             cfg_append_en,
  input  logic             cfg_fcs32,
  input  logic             cfg_inj_manual,
  input  logic [CNT_W-1:0] cfg_inj_count,
  input  logic [CNT_W-1:0] cfg_inj_period,
  input  logic             inj_trig,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop
);
  localparam int unsigned BCNT_W = $clog2(CRC_W / BYTE_W);

  logic              st_fcs_q, st_fcs_d;
  logic [BCNT_W-1:0] cnt_q, cnt_d;
  logic              pk_app_q, pk_app_d, pk_wide_q, pk_wide_d;
  logic              eff_app, eff_wide, in_fire, out_fire, last_fcs, pkt_start;
  logic [CRC_W-1:0]  crc_q, err_mask, fcs_word;
  logic              pkt_err;
  logic [IDX_W-1:0]  pkt_idx;

  assign eff_app   = in_sop ? (cfg_proc_en & cfg_append_en) : pk_app_q;
  assign eff_wide  = in_sop ? cfg_fcs32 : pk_wide_q;
  assign in_ready  = !st_fcs_q && out_ready;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign last_fcs  = cnt_q == (pk_wide_q ? BCNT_W'(CRC_W / BYTE_W - 1) : BCNT_W'(1));
  assign pkt_start = in_fire && in_sop && cfg_proc_en && cfg_append_en;
  assign err_mask  = pkt_err ? (CRC_W'(1) << pkt_idx) : '0;
  assign fcs_word  = ~crc_q ^ err_mask;

  fcs_crc_unit u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_en(in_fire),
    .first  (in_sop),
    .wide   (eff_wide),
    .data   (in_data),
    .crc_q  (crc_q)
  );

  fcs_err_sched #(.CNT_W(CNT_W)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (inj_trig),
    .manual   (cfg_inj_manual),
    .cnt_cfg  (cfg_inj_count),
    .per_cfg  (cfg_inj_period),
    .pkt_start(pkt_start),
    .wide     (cfg_fcs32),
    .pkt_err  (pkt_err),
    .pkt_idx  (pkt_idx)
  );

  always_comb begin
    if (st_fcs_q) begin
      out_valid = 1'b1;
      out_data  = fcs_word[BYTE_W*cnt_q +: BYTE_W];
      out_sop   = 1'b0;
      out_eop   = last_fcs;
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
      out_sop   = in_valid && in_sop;
      out_eop   = in_valid && in_eop && !eff_app;
    end
  end

  always_comb begin
    st_fcs_d  = st_fcs_q;
    cnt_d     = cnt_q;
    pk_app_d  = pk_app_q;
    pk_wide_d = pk_wide_q;
    if (in_fire && in_sop) begin
      pk_app_d  = cfg_proc_en && cfg_append_en;
      pk_wide_d = cfg_fcs32;
    end
    if (in_fire && in_eop && eff_app) begin
      st_fcs_d = 1'b1;
      cnt_d    = '0;
    end
    if (st_fcs_q && out_fire) begin
      if (last_fcs) st_fcs_d = 1'b0;
      else          cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_fcs_q  <= 1'b0;
      cnt_q     <= '0;
      pk_app_q  <= 1'b0;
      pk_wide_q <= 1'b0;
    end else begin
      st_fcs_q  <= st_fcs_d;
      cnt_q     <= cnt_d;
      pk_app_q  <= pk_app_d;
      pk_wide_q <= pk_wide_d;
    end
  end
endmodule

// File: rtl/fcs_inserter_chk.sv
module fcs_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_eop,
  input logic       st_fcs,
  input logic       pk_app
);
  AST_TRAILER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fcs && !out_ready) |=> (st_fcs && out_valid && $stable(out_data))); // R5
  AST_TRAILER_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    st_fcs |-> !in_ready); // R4
  AST_EOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid); // R4
  AST_DATA_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !st_fcs) |-> (in_valid && out_data == in_data)); // R4
  AST_TRAILER_NEEDS_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    st_fcs |-> pk_app); // R6
endmodule

bind fcs_inserter fcs_inserter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_eop  (out_eop),
  .st_fcs   (st_fcs_q),
  .pk_app   (pk_app_q)
);

// File: tb/sim_fcs_inserter.sv
`timescale 1ns/1ps
module sim_fcs_inserter;
  logic clk, rst_n;
  logic cfg_proc_en, cfg_append_en, cfg_fcs32, cfg_inj_manual, inj_trig;
  logic [7:0] cfg_inj_count, cfg_inj_period;
  logic in_valid, in_ready, in_sop, in_eop, out_valid, out_ready, out_sop, out_eop;
  logic [7:0] in_data, out_data;

  fcs_inserter u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_fail;
  bit finished;
  logic [7:0] pkt_b [80];
  logic [7:0] exp_b [80];
  logic [7:0] rx_b  [80];
  bit rx_sop [80];
  bit rx_eop [80];
  int m_rem, m_gap, m_idx;
  bit m_pend;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int len, input bit wide);
    logic [31:0] c;
    bit fb;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ pkt_b[i][j];
        c = c >> 1;
        if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
      end
    return ~c & (wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
  endfunction

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) pkt_b[i] = 8'((seed * 37 + i * 13 + 5) & 255);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0;
    out_ready = 1; inj_trig = 0;
    m_rem = 0; m_gap = 0; m_idx = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic trigger();
    @(negedge clk);
    inj_trig = 1'b1;
    if (cfg_inj_manual) m_pend = 1;
    else begin m_rem = int'(cfg_inj_count); m_gap = 0; end
    @(negedge clk);
    inj_trig = 1'b0;
  endtask

  task automatic send_pkt(input int len, input bit stall, input bit flip, input string tag);
    bit app, wide, hit, fin, ok;
    logic [31:0] clean, word, mask, rxw;
    int nb, exp_n, idx, got, cyc, cur, bad;
    app = cfg_proc_en && cfg_append_en;
    wide = cfg_fcs32;
    nb = wide ? 4 : 2;
    mask = 0;
    for (int i = 0; i < len; i++) exp_b[i] = pkt_b[i];
    exp_n = len;
    hit = 0;
    clean = ref_fcs(len, wide);
    if (app) begin
      hit = cfg_inj_manual ? m_pend : (m_rem != 0 && m_gap == 0);
      if (hit) begin
        cur = wide ? m_idx : m_idx % 16;
        mask = 32'(1) << cur;
        m_idx = (m_idx >= (wide ? 31 : 15)) ? 0 : m_idx + 1;
      end
      if (cfg_inj_manual) begin
        if (hit) m_pend = 0;
      end else if (m_rem != 0) begin
        if (m_gap == 0) begin
          m_rem--;
          m_gap = (cfg_inj_period == 0) ? 0 : int'(cfg_inj_period) - 1;
        end else m_gap--;
      end
      word = clean ^ mask;
      for (int k = 0; k < nb; k++) exp_b[len + k] = word[8*k +: 8];
      exp_n = len + nb;
    end
    idx = 0; got = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 2000 && got < 80) begin
      @(negedge clk);
      if (flip && idx >= 1) cfg_fcs32 = !wide;
      out_ready = !(stall && (cyc % 3 == 1));
      in_valid = idx < len;
      in_data = (idx < len) ? pkt_b[idx] : 8'h00;
      in_sop = idx == 0;
      in_eop = idx == len - 1;
      #1;
      if (out_valid && out_ready) begin
        rx_b[got] = out_data; rx_sop[got] = out_sop; rx_eop[got] = out_eop;
        got++;
        if (out_eop) fin = 1;
      end
      if (in_valid && in_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; out_ready = 1;
    cfg_fcs32 = wide;
    if (got != exp_n) chk(0, tag, "byte count", got, exp_n);
    else begin
      ok = 1; bad = -1;
      for (int i = 0; i < exp_n; i++)
        if (rx_b[i] !== exp_b[i] || rx_sop[i] != (i == 0) || rx_eop[i] != (i == exp_n - 1)) begin
          if (bad < 0) bad = i;
          ok = 0;
        end
      if (ok) chk(1, tag, "stream", 0, 0);
      else chk(0, tag, $sformatf("byte %0d", bad), rx_b[bad], exp_b[bad]);
      if (app && hit) begin
        rxw = 0;
        for (int k = 0; k < nb; k++) rxw[8*k +: 8] = rx_b[len + k];
        chk($countones(rxw ^ clean) == 1, "R8", "flipped bit count",
            $countones(rxw ^ clean), 1);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    cfg_proc_en = 1; cfg_append_en = 1; cfg_fcs32 = 1; cfg_inj_manual = 1;
    cfg_inj_count = 0; cfg_inj_period = 0;
    do_reset();
    #1;
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    for (int i = 0; i < 9; i++) pkt_b[i] = 8'(8'h31 + i);
    send_pkt(9, 0, 0, "R2");
    chk({rx_b[9], rx_b[10], rx_b[11], rx_b[12]} == 32'h2639_F4CB, "R2", "known trailer",
        {rx_b[9], rx_b[10], rx_b[11], rx_b[12]}, 32'h2639_F4CB);
    cfg_fcs32 = 0;
    send_pkt(9, 1, 0, "R3");
    chk({rx_b[9], rx_b[10]} == 16'h6E90, "R3", "known trailer", {rx_b[9], rx_b[10]}, 16'h6E90);

    // Sweep length x width x back-pressure (R4, R5)
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int l = 1; l <= 12; l++) begin
          cfg_fcs32 = 1'(w);
          fill(l, l + 20 * w + 40 * s);
          send_pkt(l, 1'(s), 0, s ? "R5" : "R4");
        end

    // R6: no trailer
    cfg_append_en = 0;
    for (int l = 1; l <= 4; l++) begin fill(l, l + 7); send_pkt(l, 0, 0, "R6"); end
    cfg_append_en = 1;

    // R7 and R12: bypassed packets keep a pending manual request
    cfg_inj_manual = 1; cfg_fcs32 = 1;
    trigger();
    cfg_proc_en = 0;
    fill(5, 3); send_pkt(5, 1, 0, "R7");
    cfg_proc_en = 1; cfg_append_en = 0;
    fill(3, 4); send_pkt(3, 0, 0, "R12");
    cfg_append_en = 1;
    fill(6, 5); send_pkt(6, 0, 0, "R12");
    // R11: merged pulses give one corrupted packet
    trigger(); trigger();
    fill(4, 6); send_pkt(4, 0, 0, "R11");
    fill(4, 7); send_pkt(4, 0, 0, "R11");

    // R10: programmed burst, count 3 every 2nd packet
    cfg_inj_manual = 0; cfg_inj_count = 3; cfg_inj_period = 2;
    trigger();
    for (int p = 0; p < 8; p++) begin fill(3 + p, 50 + p); send_pkt(3 + p, p[0], 0, "R10"); end
    cfg_inj_count = 2; cfg_inj_period = 0;
    trigger();
    for (int p = 0; p < 3; p++) begin fill(2, 60 + p); send_pkt(2, 0, 0, "R10"); end

    // R9: 16-bit index wrap over a long burst
    do_reset();
    cfg_fcs32 = 0; cfg_inj_count = 18; cfg_inj_period = 1;
    trigger();
    for (int p = 0; p < 19; p++) begin fill(4, 70 + p); send_pkt(4, 0, 0, "R9"); end
    // stored index above 15 used in 16-bit mode
    do_reset();
    cfg_fcs32 = 1; cfg_inj_count = 20; cfg_inj_period = 1;
    trigger();
    for (int p = 0; p < 19; p++) begin fill(2, 90 + p); send_pkt(2, 0, 0, "R9"); end
    cfg_fcs32 = 0;
    fill(3, 120); send_pkt(3, 0, 0, "R9");

    // R13: width flips after the first byte, packet keeps its setting
    do_reset();
    cfg_fcs32 = 1;
    fill(6, 130); send_pkt(6, 0, 1, "R13");
    cfg_fcs32 = 0;
    fill(7, 131); send_pkt(7, 1, 1, "R13");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule